// File: doc/BRIEF.md
# Video Sync Output Conditioner

The conditioner sits between a video receiver's line-locked timing generator and downstream video transmitters. Every pixel clock it takes horizontal sync, vertical sync, field and the horizontal and vertical blanking strobes. It re-times horizontal sync by a programmable number of pixel clocks. It re-times vertical sync and field by a programmable number of whole lines, counted on the rising edges of the undelayed horizontal sync. From the re-timed horizontal and vertical sync it builds a composite sync, and from the blanking strobes it builds a data-enable that is high over active video.

Composite sync and data-enable each have a static polarity control. The vertical sync output can come from either source below, chosen by one configuration bit:
- the re-timed, clock-synchronous vertical sync;
- an unclocked vertical sync input, passed straight through with no register. This path stays usable when the pixel clock is not locked.

Top module: `sync_out_cond`

## Requirements
- R1: `csync_out` equals the exclusive-OR of `hs_out` and the clock-synchronous delayed vertical sync, inverted when `cfg_csync_inv` is 1. It changes in the same cycle as those two signals, so horizontal pulses are serrated while vertical sync is active.
- R2: One clock after a sample, `de_out` is 1 when neither `hblank_in` nor `vblank_in` was 1 in that sample. `cfg_de_inv` = 1 inverts this output.
- R3: `hs_out` reproduces `hs_in` delayed by `cfg_hs_dly` + 1 pixel clocks. `cfg_hs_dly` ranges from 0 to 255, and 0 leaves only one register stage.
- R4: A line boundary is a clock in which `hs_in` is 1 while it was 0 in the previous clock. Each boundary records `vs_in`. With `cfg_vs_dly` = N > 0, the synchronous vertical sync one clock later is the value recorded N boundaries before the most recent one, or 0 if fewer than N boundaries have occurred. With N = 0, it is `vs_in` delayed by one clock. N ranges from 0 to 15.
- R5: `fld_out` follows the R4 rule applied to `fld_in` with its own delay `cfg_fld_dly`.
- R6: With `cfg_vs_raw` = 1, `vs_fld_out` equals `vs_raw_in` through combinational logic only. With `cfg_vs_raw` = 0, it carries the synchronous delayed vertical sync.
- R7: While reset is applied, and through the two clocks of synchronous reset release:
  - `hs_out`, `fld_out` and the synchronous vertical sync are 0;
  - `csync_out` equals `cfg_csync_inv`;
  - `de_out` equals `cfg_de_inv`.
- R8: With a nonzero line delay held constant, the line-delayed outputs change only in the clock that follows a line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hs_in | input | 1 | Horizontal sync, active high |
| vs_in | input | 1 | Vertical sync, active high, pixel-clock synchronous |
| fld_in | input | 1 | Field indicator |
| hblank_in | input | 1 | Horizontal blanking, active high |
| vblank_in | input | 1 | Vertical blanking, active high |
| vs_raw_in | input | 1 | Unclocked vertical sync for the bypass route |
| cfg_csync_inv | input | 1 | Invert composite sync |
| cfg_de_inv | input | 1 | Invert data-enable |
| cfg_vs_raw | input | 1 | 1 selects the unclocked vertical sync for `vs_fld_out` |
| cfg_hs_dly | input | 8 | Horizontal sync delay in pixel clocks |
| cfg_vs_dly | input | 4 | Vertical sync delay in lines |
| cfg_fld_dly | input | 4 | Field delay in lines |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_fld_out | output | 1 | Selected vertical sync |
| fld_out | output | 1 | Line-delayed field |
| csync_out | output | 1 | Composite sync |
| de_out | output | 1 | Data-enable |

## Verification
On every cycle, the assertions check the following:
- the alignment of composite sync with the two sync outputs it is built from;
- the single-stage pass-through at zero pixel delay;
- the one-clock blanking-to-data-enable relation;
- that line-delayed outputs hold still between line boundaries;
- that the outputs are idle under reset.

Some behaviour only the bench's scenarios can show. These are the exact multi-cycle and multi-line delays at values such as 255 pixels and 15 lines, and the history carried across delay changes made in mid-frame. The bench scenarios also cover the combinational bypass route and the polarity controls, under both framed timing and random sync streams.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;
  localparam int HS_DLY_W_DEF = 8;
  localparam int LN_DLY_W_DEF = 4;
  localparam int LANES        = 2;
  localparam int LANE_VS      = 0;
  localparam int LANE_FLD     = 1;

  typedef enum logic {
    VS_SRC_LOCKED = 1'b0,
    VS_SRC_RAW    = 1'b1
  } vs_src_e;
endpackage

// File: rtl/sync_pix_delay.sv
module sync_pix_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic         din,
  input  logic [W-1:0] dly,
  output logic         q_nxt,
  output logic         q
);
  localparam int          DEPTH = (1 << W) - 1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_d;
  logic             q_d;
  logic             run_q;

  always_comb begin
    sr_d = {sr_q[DEPTH-2:0], din};
    if (dly == '0) q_d = din;
    else           q_d = sr_q[dly - ONE];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      sr_q  <= '0;
      q     <= 1'b0;
      run_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      q     <= q_d;
      run_q <= 1'b1;
    end
  end

  assign q_nxt = q_d;

  // R3: zero delay leaves exactly one register stage
  p_hs_zero_dly_r3: assert property (@(posedge clk) disable iff (!rst_l)
    (run_q && dly == '0) |=> (q == $past(din)));
endmodule

// File: rtl/sync_line_delay.sv
module sync_line_delay #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_l,
  input  logic         adv,
  input  logic         din,
  input  logic [W-1:0] dly,
  output logic         q_nxt,
  output logic         q
);
  localparam int           DEPTH = (1 << W) - 1;
  localparam logic [W-1:0] ONE   = W'(1);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;
  logic             hist_en;
  logic             q_d;
  logic             adv_q;
  logic             run_q;

  always_comb begin
    hist_en = adv;
    hist_d  = {hist_q[DEPTH-2:0], din};
    if (dly == '0) q_d = din;
    else           q_d = hist_q[dly - ONE];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      hist_q <= '0;
      q      <= 1'b0;
      adv_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (hist_en) hist_q <= hist_d;
      q     <= q_d;
      adv_q <= adv;
      run_q <= 1'b1;
    end
  end

  assign q_nxt = q_d;

  // R8: a nonzero line delay output moves only after a line boundary
  p_line_hold_r8: assert property (@(posedge clk) disable iff (!rst_l)
    (run_q && !adv && !adv_q && dly != '0 && $stable(dly)) |=> $stable(q));
endmodule

// File: rtl/sync_combine.sv
module sync_combine (
  input  logic clk,
  input  logic rst_l,
  input  logic hs_nxt,
  input  logic vs_nxt,
  input  logic hblank,
  input  logic vblank,
  input  logic csync_inv,
  input  logic de_inv,
  output logic csync_out,
  output logic de_out
);
  logic csync_d, csync_q;
  logic de_d, de_q;
  logic run_q;

  always_comb begin
    csync_d = hs_nxt ^ vs_nxt;
    de_d    = ~(hblank | vblank);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      csync_q <= 1'b0;
      de_q    <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      csync_q <= csync_d;
      de_q    <= de_d;
      run_q   <= 1'b1;
    end
  end

  assign csync_out = csync_q ^ csync_inv;
  assign de_out    = de_q ^ de_inv;

  // R2: data-enable tracks blanking one clock later
  p_de_blank_r2: assert property (@(posedge clk) disable iff (!rst_l)
    run_q |=> ((de_out ^ de_inv) == !($past(hblank) || $past(vblank))));
endmodule

// File: rtl/sync_out_cond.sv
module sync_out_cond
  import sync_cond_pkg::*;
#(
  parameter int HS_DLY_W = HS_DLY_W_DEF,
  parameter int LN_DLY_W = LN_DLY_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hs_in,
  input  logic                vs_in,
  input  logic                fld_in,
  input  logic                hblank_in,
  input  logic                vblank_in,
  input  logic                vs_raw_in,
  input  logic                cfg_csync_inv,
  input  logic                cfg_de_inv,
  input  logic                cfg_vs_raw,
  input  logic [HS_DLY_W-1:0] cfg_hs_dly,
  input  logic [LN_DLY_W-1:0] cfg_vs_dly,
  input  logic [LN_DLY_W-1:0] cfg_fld_dly,
  output logic                hs_out,
  output logic                vs_fld_out,
  output logic                fld_out,
  output logic                csync_out,
  output logic                de_out
);
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  logic hs_prev_q;
  logic line_adv;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) hs_prev_q <= 1'b0;
    else        hs_prev_q <= hs_in;
  end
  assign line_adv = hs_in & ~hs_prev_q;

  logic hs_nxt, hs_q;

  sync_pix_delay #(.W(HS_DLY_W)) u_hs_dly (
    .clk   (clk),
    .rst_l (rst_l),
    .din   (hs_in),
    .dly   (cfg_hs_dly),
    .q_nxt (hs_nxt),
    .q     (hs_q)
  );

  logic [LANES-1:0]               ln_din;
  logic [LANES-1:0][LN_DLY_W-1:0] ln_dly;
  logic [LANES-1:0]               ln_nxt;
  logic [LANES-1:0]               ln_q;

  always_comb begin
    ln_din[LANE_VS]  = vs_in;
    ln_din[LANE_FLD] = fld_in;
    ln_dly[LANE_VS]  = cfg_vs_dly;
    ln_dly[LANE_FLD] = cfg_fld_dly;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sync_line_delay #(.W(LN_DLY_W)) u_ln (
      .clk   (clk),
      .rst_l (rst_l),
      .adv   (line_adv),
      .din   (ln_din[g]),
      .dly   (ln_dly[g]),
      .q_nxt (ln_nxt[g]),
      .q     (ln_q[g])
    );
  end

  sync_combine u_comb (
    .clk       (clk),
    .rst_l     (rst_l),
    .hs_nxt    (hs_nxt),
    .vs_nxt    (ln_nxt[LANE_VS]),
    .hblank    (hblank_in),
    .vblank    (vblank_in),
    .csync_inv (cfg_csync_inv),
    .de_inv    (cfg_de_inv),
    .csync_out (csync_out),
    .de_out    (de_out)
  );

  vs_src_e vs_src;
  assign vs_src = vs_src_e'(cfg_vs_raw);

  always_comb begin
    if (vs_src == VS_SRC_RAW) vs_fld_out = vs_raw_in;
    else                      vs_fld_out = ln_q[LANE_VS];
  end

  assign hs_out  = hs_q;
  assign fld_out = ln_q[LANE_FLD];

  // R1: composite sync stays aligned with the two outputs it combines
  p_csync_xor_r1: assert property (@(posedge clk) disable iff (!rst_l)
    ((csync_out ^ cfg_csync_inv) == (hs_out ^ ln_q[LANE_VS])));

  // R7: registered outputs idle while internal reset is held
  p_reset_idle_r7: assert property (@(posedge clk)
    !rst_l |-> (!hs_out && !fld_out && !ln_q[LANE_VS]
                && (csync_out == cfg_csync_inv) && (de_out == cfg_de_inv)));
endmodule

// File: tb/tb_sync_out_cond.sv
`timescale 1ns/1ps
module tb_sync_out_cond;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hs_in, vs_in, fld_in, hblank_in, vblank_in, vs_raw_in;
  logic       cfg_csync_inv, cfg_de_inv, cfg_vs_raw;
  logic [7:0] cfg_hs_dly;
  logic [3:0] cfg_vs_dly, cfg_fld_dly;
  logic       hs_out, vs_fld_out, fld_out, csync_out, de_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  sync_out_cond dut (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .vs_in(vs_in), .fld_in(fld_in),
    .hblank_in(hblank_in), .vblank_in(vblank_in), .vs_raw_in(vs_raw_in),
    .cfg_csync_inv(cfg_csync_inv), .cfg_de_inv(cfg_de_inv), .cfg_vs_raw(cfg_vs_raw),
    .cfg_hs_dly(cfg_hs_dly), .cfg_vs_dly(cfg_vs_dly), .cfg_fld_dly(cfg_fld_dly),
    .hs_out(hs_out), .vs_fld_out(vs_fld_out), .fld_out(fld_out),
    .csync_out(csync_out), .de_out(de_out)
  );

  // bench model state
  bit hsbuf [0:255];
  bit vline [0:14];
  bit fline [0:14];
  bit hs_prev;
  bit e_hs, e_vs, e_fld, e_de_act;

  function automatic bit line_pick(bit cur, bit hist [0:14], int n);
    return (n == 0) ? cur : hist[n-1];
  endfunction

  function automatic bit de_level(bit hb, bit vb, bit inv);
    return (!(hb || vb)) ^ inv;
  endfunction

  task automatic chk(string req, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 256; i++) hsbuf[i] = 0;
    for (int i = 0; i < 15; i++) begin vline[i] = 0; fline[i] = 0; end
    hs_prev = 0;
  endtask

  task automatic model_step();
    for (int i = 255; i > 0; i--) hsbuf[i] = hsbuf[i-1];
    hsbuf[0] = hs_in;
    e_hs  = hsbuf[cfg_hs_dly];
    e_vs  = line_pick(vs_in, vline, int'(cfg_vs_dly));
    e_fld = line_pick(fld_in, fline, int'(cfg_fld_dly));
    e_de_act = !(hblank_in || vblank_in);
    if (hs_in && !hs_prev) begin
      for (int i = 14; i > 0; i--) begin vline[i] = vline[i-1]; fline[i] = fline[i-1]; end
      vline[0] = vs_in;
      fline[0] = fld_in;
    end
    hs_prev = hs_in;
  endtask

  task automatic drive_zero();
    hs_in = 0; vs_in = 0; fld_in = 0; hblank_in = 0; vblank_in = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < 5; i++) begin
      hs_in = 1'($urandom); vs_in = 1'($urandom); fld_in = 1'($urandom);
      hblank_in = 1'($urandom); vblank_in = 1'($urandom);
      cfg_csync_inv = 1'(i); cfg_de_inv = 1'(i >> 1);
      @(posedge clk); @(negedge clk);
      chk("R7 hs", hs_out, 1'b0);
      chk("R7 fld", fld_out, 1'b0);
      chk("R7 csync", csync_out, cfg_csync_inv);
      chk("R7 de", de_out, cfg_de_inv);
      if (!cfg_vs_raw) chk("R7 vs", vs_fld_out, 1'b0);
    end
    drive_zero();
    model_clear();
    rst_n = 1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R7 release hs", hs_out, 1'b0);
      chk("R7 release de", de_out, cfg_de_inv);
    end
    @(posedge clk); @(negedge clk);
  endtask

  // one cycle: inputs already driven at a negedge
  task automatic cycle();
    #1;
    if (cfg_vs_raw) chk("R6 raw route", vs_fld_out, vs_raw_in);
    model_step();
    @(posedge clk); @(negedge clk);
    chk("R3 hs delay", hs_out, e_hs);
    chk("R4/R8 vs delay", cfg_vs_raw ? vs_fld_out : vs_fld_out, cfg_vs_raw ? vs_raw_in : e_vs);
    chk("R5 fld delay", fld_out, e_fld);
    chk("R1 csync", csync_out, (e_hs ^ e_vs) ^ cfg_csync_inv);
    chk("R2 de", de_out, e_de_act ^ cfg_de_inv);
  endtask

  task automatic framed(int cycles, bit rnd_raw);
    int pix = 0, ln = 0;
    bit fld = 0;
    for (int c = 0; c < cycles; c++) begin
      hs_in = (pix < 3);
      hblank_in = (pix < 8);
      vs_in = (ln >= 1 && ln <= 2);
      vblank_in = (ln < 4);
      fld_in = fld;
      vs_raw_in = rnd_raw ? 1'($urandom) : vs_in;
      cycle();
      pix++;
      if (pix == 30) begin
        pix = 0; ln++;
        if (ln == 20) begin ln = 0; fld = !fld; end
      end
    end
  endtask

  task automatic random_run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      hs_in = ($urandom % 4) == 0;
      vs_in = 1'($urandom);
      fld_in = 1'($urandom);
      hblank_in = ($urandom % 3) == 0;
      vblank_in = ($urandom % 5) == 0;
      vs_raw_in = 1'($urandom);
      if (c % 97 == 0) begin
        cfg_hs_dly = 8'($urandom); cfg_vs_dly = 4'($urandom); cfg_fld_dly = 4'($urandom);
        cfg_csync_inv = 1'($urandom); cfg_de_inv = 1'($urandom); cfg_vs_raw = 1'($urandom);
      end
      cycle();
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    drive_zero(); vs_raw_in = 0;
    cfg_csync_inv = 0; cfg_de_inv = 0; cfg_vs_raw = 0;
    cfg_hs_dly = 0; cfg_vs_dly = 0; cfg_fld_dly = 0;
    do_reset();

    // R3 zero delays, pass-through with one register stage
    framed(1300, 0);
    // R3 maximum pixel delay, R4/R5 maximum line delay, R8
    cfg_hs_dly = 8'd255; cfg_vs_dly = 4'd15; cfg_fld_dly = 4'd15;
    framed(12500, 0);
    // R1/R2 polarity inversion with mid-range delays
    cfg_csync_inv = 1; cfg_de_inv = 1;
    cfg_hs_dly = 8'd7; cfg_vs_dly = 4'd1; cfg_fld_dly = 4'd3;
    framed(3000, 0);
    // R6 unclocked vertical sync route
    cfg_vs_raw = 1;
    framed(800, 1);
    cfg_vs_raw = 0;
    // delay changes in mid-frame keep history
    cfg_hs_dly = 8'd1; cfg_vs_dly = 4'd2;
    framed(600, 0);
    // R7 second reset with inversion active
    do_reset();
    random_run(20000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule